// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters and a global history register holding the outcomes of the most recent branches. A counter is selected by an index that places the history bits above a slice of the branch address. The predictor learns which way each branch tends to go, and the history bits let it tell apart the cases that come before each branch.

Each request carries a branch address and the branch's resolved direction. In the cycle a request is accepted, the block reads the selected counter and forms the prediction. At the next clock edge it registers the mispredict flag, moves the counter one step toward the resolved direction and shifts that direction into the history. The prediction bit is also driven straight out of the table for the request being presented.

After reset the block clears its table one storage row per cycle and holds busy high while it does so. Requests presented during that sweep are dropped.

Top module: `gh_dir_predictor`

## Requirements
- R1: After a reset sweep completes, every counter reads zero, so `predTaken` is 0 for every address. The history register is also zero at that point.
- R2: The counter index is `{history[HIST_BITS-1:0], reqAddr[ALIGN_SHIFT +: ADDR_BITS]}`, with the history forming the upper field. The table holds 2^(HIST_BITS+ADDR_BITS) counters, each two bits wide.
- R3: `predTaken` is 1 exactly when the counter selected by the presented address and the current history holds 2 or 3. It follows the inputs combinationally.
- R4: When an accepted request has `reqTaken`=1, its counter increases by one, and a counter at 3 stays at 3.
- R5: When an accepted request has `reqTaken`=0, its counter decreases by one, and a counter at 0 stays at 0.
- R6: Every accepted request shifts the history left by one place and enters `reqTaken` at bit 0. History bits shifted past bit HIST_BITS-1 are discarded.
- R7: The lowest ALIGN_SHIFT address bits and all address bits above ALIGN_SHIFT+ADDR_BITS-1 do not affect the index.
- R8: A request is accepted when `reqValid`=1 and `busy`=0. One cycle after acceptance `respValid` is 1, and `respMispredict` is 1 exactly when the prediction made for that request differs from `reqTaken`.
- R9: After reset is released, `busy` stays high for exactly ROWS = 2^(HIST_BITS+ADDR_BITS-SLOT_LOG2) cycles. A request presented while `busy` is high gives no `respValid` and changes neither the counters nor the history.
- R10: Requests may be accepted on consecutive cycles. Each request sees the counter and history updates made by the request before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts the clearing sweep |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | PC_W | Branch instruction address |
| reqTaken | input | 1 | Resolved direction of the branch (1 = taken) |
| busy | output | 1 | High while the table is being cleared; requests are refused |
| predTaken | output | 1 | Upper bit of the currently indexed counter (prediction) |
| respValid | output | 1 | Result valid, one cycle after an accepted request |
| respMispredict | output | 1 | 1 when the prediction and the resolved direction differed |

## Verification
The bench builds the block with three history bits, three address bits, an alignment shift of two and four counters per storage row. That gives 64 counters in 16 rows, so the sweep length can be counted exactly and every address can be scanned for the all-zero state. With only three history bits, runs of equal outcomes quickly drive the history to all ones or all zeros. Counters can then be pushed into both saturation points. A long back-to-back pseudo-random stream is compared against an arithmetic model of the counter table and the history.

// File: rtl/gh_pred_pkg.sv
`timescale 1ns/1ps
package gh_pred_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearRow;  // zero the row addressed by the sweep pointer
    logic commit;    // accept the presented request
  } predStrobe_t;

  // Move a two-bit counter one step toward the resolved direction
  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
    else    nxt = (cur == 2'd0) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/gh_pred_ctrl.sv
`timescale 1ns/1ps
module gh_pred_ctrl
  import gh_pred_pkg::*;
#(
  parameter int ROWS = 1024
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reqValid,
  output predStrobe_t             strobe,
  output logic [$clog2(ROWS)-1:0] clrRow,
  output logic                    busy
);
  localparam int PTR_W = $clog2(ROWS);

  logic [PTR_W-1:0] sweepPtr;
  logic             busyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ    <= 1'b1;
      sweepPtr <= '0;
    end else if (busyQ) begin
      sweepPtr <= sweepPtr + 1'b1;
      if (sweepPtr == PTR_W'(ROWS - 1)) busyQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.clearRow = busyQ;
    strobe.commit   = reqValid && !busyQ && !rst;
  end

  assign clrRow = sweepPtr;
  assign busy   = busyQ;

endmodule

// File: rtl/gh_pred_datapath.sv
`timescale 1ns/1ps
module gh_pred_datapath
  import gh_pred_pkg::*;
#(
  parameter int HIST_BITS   = 7,
  parameter int ADDR_BITS   = 7,
  parameter int ALIGN_SHIFT = 2,
  parameter int SLOT_LOG2   = 4,
  parameter int PC_W        = 32,
  localparam int IDX_W      = HIST_BITS + ADDR_BITS,
  localparam int ROW_W      = IDX_W - SLOT_LOG2,
  localparam int ROWS       = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  predStrobe_t      strobe,
  input  logic [ROW_W-1:0] clrRow,
  input  logic [PC_W-1:0]  reqAddr,
  input  logic             reqTaken,
  output logic             predTaken,
  output logic             respValid,
  output logic             respMispredict
);
  localparam int SLOTS  = 1 << SLOT_LOG2;
  localparam int LINE_W = 2 * SLOTS;
  localparam int TOP_LO = ALIGN_SHIFT + ADDR_BITS;

  logic [HIST_BITS-1:0] hist;
  logic [LINE_W-1:0]    tbl [ROWS];

  logic [IDX_W-1:0]     idx;
  logic [ROW_W-1:0]     rowSel;
  logic [SLOT_LOG2-1:0] slotSel;
  logic [LINE_W-1:0]    curLine;
  logic [LINE_W-1:0]    newLine;
  logic [1:0]           curCnt;
  logic [1:0]           nxtCnt;

  // Index: history above the aligned address slice
  assign idx     = {hist, reqAddr[ALIGN_SHIFT +: ADDR_BITS]};
  assign rowSel  = idx[IDX_W-1 -: ROW_W];
  assign slotSel = idx[SLOT_LOG2-1:0];
  assign curLine = tbl[rowSel];
  assign curCnt  = curLine[{slotSel, 1'b0} +: 2];
  assign nxtCnt  = satStep(curCnt, reqTaken);

  assign predTaken = curCnt[1];

  // Merge the stepped counter back into its row
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    assign newLine[2*g +: 2] = (slotSel == SLOT_LOG2'(g)) ? nxtCnt : curLine[2*g +: 2];
  end

  // Address bits that never reach the index
  if (ALIGN_SHIFT > 0) begin : gLowBits
    logic unusedLow;
    assign unusedLow = ^reqAddr[ALIGN_SHIFT-1:0];
  end
  if (PC_W > TOP_LO) begin : gHighBits
    logic unusedHigh;
    assign unusedHigh = ^reqAddr[PC_W-1:TOP_LO];
  end

  // Counter table: a sweep write or a request update, one row per cycle
  always_ff @(posedge clk) begin
    if (strobe.clearRow)    tbl[clrRow] <= '0;
    else if (strobe.commit) tbl[rowSel] <= newLine;
  end

  // History and response
  always_ff @(posedge clk) begin
    if (rst) begin
      hist           <= '0;
      respValid      <= 1'b0;
      respMispredict <= 1'b0;
    end else begin
      respValid <= strobe.commit;
      if (strobe.commit) begin
        hist           <= HIST_BITS'({hist, reqTaken});
        respMispredict <= curCnt[1] ^ reqTaken;
      end
    end
  end

endmodule

// File: rtl/gh_dir_predictor.sv
`timescale 1ns/1ps
module gh_dir_predictor
  import gh_pred_pkg::*;
#(
  parameter int HIST_BITS   = 7,
  parameter int ADDR_BITS   = 7,
  parameter int ALIGN_SHIFT = 2,
  parameter int SLOT_LOG2   = 4,
  parameter int PC_W        = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reqValid,
  input  logic [PC_W-1:0] reqAddr,
  input  logic            reqTaken,
  output logic            busy,
  output logic            predTaken,
  output logic            respValid,
  output logic            respMispredict
);
  localparam int ROW_W = HIST_BITS + ADDR_BITS - SLOT_LOG2;
  localparam int ROWS  = 1 << ROW_W;

  predStrobe_t      strobe;
  logic [ROW_W-1:0] clrRow;

  gh_pred_ctrl #(.ROWS(ROWS)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .strobe   (strobe),
    .clrRow   (clrRow),
    .busy     (busy)
  );

  gh_pred_datapath #(
    .HIST_BITS   (HIST_BITS),
    .ADDR_BITS   (ADDR_BITS),
    .ALIGN_SHIFT (ALIGN_SHIFT),
    .SLOT_LOG2   (SLOT_LOG2),
    .PC_W        (PC_W)
  ) uData (
    .clk            (clk),
    .rst            (rst),
    .strobe         (strobe),
    .clrRow         (clrRow),
    .reqAddr        (reqAddr),
    .reqTaken       (reqTaken),
    .predTaken      (predTaken),
    .respValid      (respValid),
    .respMispredict (respMispredict)
  );

endmodule

// File: rtl/gh_dir_predictor_chk.sv
`timescale 1ns/1ps
module gh_dir_predictor_chk #(
  parameter int ROWS = 1024
) (
  input logic clk,
  input logic rst,
  input logic reqValid,
  input logic reqTaken,
  input logic busy,
  input logic predTaken,
  input logic respValid,
  input logic respMispredict
);
  localparam int CNT_W = $clog2(ROWS) + 2;

  logic [CNT_W-1:0] sweepCnt;

  always_ff @(posedge clk) begin
    if (rst)       sweepCnt <= '0;
    else if (busy) sweepCnt <= sweepCnt + 1'b1;
  end

  // R9: the sweep lasts exactly ROWS cycles
  a_r9_sweep_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> sweepCnt == CNT_W'(ROWS));

  // R9: once cleared, busy stays low until the next reset
  a_r9_busy_stays_low: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);

  // R9: nothing is answered while busy
  a_r9_busy_refuses: assert property (@(posedge clk) disable iff (rst)
    busy |=> !respValid);

  // R8: an accepted request is answered one cycle later
  a_r8_resp_follows: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !busy) |=> respValid);

  // R8: no answer without an accepted request
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    respValid |-> $past(reqValid && !busy));

  // R8: mispredict compares the prediction made with the outcome
  a_r8_mispredict_value: assert property (@(posedge clk) disable iff (rst)
    respValid |-> (respMispredict == ($past(predTaken) ^ $past(reqTaken))));

endmodule

bind gh_dir_predictor gh_dir_predictor_chk #(.ROWS(ROWS)) uChk (
  .clk            (clk),
  .rst            (rst),
  .reqValid       (reqValid),
  .reqTaken       (reqTaken),
  .busy           (busy),
  .predTaken      (predTaken),
  .respValid      (respValid),
  .respMispredict (respMispredict)
);

// File: tb/gh_dir_predictor_test.sv
`timescale 1ns/1ps
module gh_dir_predictor_test;
  localparam int H    = 3;
  localparam int A    = 3;
  localparam int SH   = 2;
  localparam int SL   = 2;
  localparam int PCW  = 16;
  localparam int NCNT = 1 << (H + A);
  localparam int ROWS = 1 << (H + A - SL);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           reqValid = 1'b0;
  logic [PCW-1:0] reqAddr = '0;
  logic           reqTaken = 1'b0;
  logic           busy, predTaken, respValid, respMispredict;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int mCnt [NCNT];
  int mHist;

  always #5 clk = ~clk;

  gh_dir_predictor #(
    .HIST_BITS(H), .ADDR_BITS(A), .ALIGN_SHIFT(SH), .SLOT_LOG2(SL), .PC_W(PCW)
  ) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqTaken(reqTaken), .busy(busy), .predTaken(predTaken),
    .respValid(respValid), .respMispredict(respMispredict)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int modelIdx(input int addr);
    return ((mHist & ((1 << H) - 1)) << A) | ((addr >> SH) & ((1 << A) - 1));
  endfunction

  task automatic modelClear();
    for (int i = 0; i < NCNT; i++) mCnt[i] = 0;
    mHist = 0;
  endtask

  // Reset and sweep; optionally present a request during the whole sweep
  task automatic doReset(input bit pokeDuringSweep);
    int cyc;
    @(negedge clk);
    rst = 1'b1;
    reqValid = pokeDuringSweep;
    reqTaken = 1'b1;
    reqAddr  = 16'h0014;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelClear();
    cyc = 0;
    while (busy && cyc < 10 * ROWS) begin
      if (pokeDuringSweep) check(respValid == 1'b0, "R9 response while busy", respValid, 0);
      cyc++;
      @(negedge clk);
    end
    check(cyc == ROWS, "R9 sweep length", cyc, ROWS);
    reqValid = 1'b0;
    #1;
    check(respValid == 1'b0, "R9 no response after refused request", respValid, 0);
  endtask

  // One request; leaves the bench at the next negedge with reqValid still high
  task automatic sendReq(input int addr, input bit taken, input string tag);
    int  i;
    bit  expPred;
    reqValid = 1'b1;
    reqAddr  = PCW'(addr);
    reqTaken = taken;
    #1;
    i = modelIdx(addr);
    expPred = (mCnt[i] >= 2);
    check(predTaken == expPred, {tag, " R3 prediction"}, predTaken, expPred);
    if (taken) mCnt[i] = (mCnt[i] == 3) ? 3 : mCnt[i] + 1;
    else       mCnt[i] = (mCnt[i] == 0) ? 0 : mCnt[i] - 1;
    mHist = ((mHist << 1) | int'(taken)) & ((1 << H) - 1);
    @(posedge clk);
    @(negedge clk);
    check(respValid == 1'b1, {tag, " R8 respValid"}, respValid, 1);
    check(respMispredict == (expPred != taken), {tag, " R8 mispredict"},
          respMispredict, int'(expPred != taken));
  endtask

  task automatic idle();
    reqValid = 1'b0;
    @(negedge clk);
    check(respValid == 1'b0, "R8 idle has no response", respValid, 0);
  endtask

  // Scan every address slice (with both ignored low bits varied) at current history
  task automatic scanAll(input string tag);
    reqValid = 1'b0;
    for (int a = 0; a < (1 << (A + SH)); a++) begin
      reqAddr = PCW'(a) | 16'hA000;
      #1;
      check(predTaken == (mCnt[modelIdx(a)] >= 2), tag, predTaken,
            int'(mCnt[modelIdx(a)] >= 2));
    end
  endtask

  initial begin
    int lfsr;
    doReset(1'b0);
    scanAll("R1 cleared table");

    // R9: requests during the sweep are dropped
    doReset(1'b1);
    scanAll("R1 R9 table untouched by refused requests");

    // R4: saturate upward
    for (int k = 0; k < 10; k++) sendReq(32'h0014, 1'b1, "R4 saturate up");
    check(mCnt[modelIdx(32'h0014)] == 3 && predTaken == 1'b1, "R4 counter at top",
          predTaken, 1);
    // R5: saturate downward (first step after saturation mispredicts)
    for (int k = 0; k < 10; k++) sendReq(32'h0014, 1'b0, "R5 saturate down");
    idle();

    // R7: ignored low and high address bits map to the same counter
    for (int k = 0; k < 6; k++) sendReq((k % 2) ? 32'hF023 : 32'h0020, 1'b1, "R7 alias");
    idle();

    // R2 R6: outcome correlated with history; index keeps the two apart
    for (int k = 0; k < 60; k++) sendReq(32'h0008 + ((k % 3) << SH), (k % 3) != 2, "R2 R6 pattern");
    idle();

    // R10: long back-to-back pseudo-random stream
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      sendReq(lfsr, ((lfsr >> 9) & 3) != 0, "R10 back-to-back");
    end
    idle();
    scanAll("R6 R2 trained table");

    // R1: reset in the middle of operation clears everything again
    doReset(1'b0);
    scanAll("R1 cleared after mid-run reset");
    sendReq(32'h0004, 1'b1, "R1 R6 first request after clear");
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule